// File: doc/BRIEF.md
# Power-Up Write Inhibit Controller

This block decides, during and after supply ramp-up of a serial memory, which decoded commands may reach the core. Three level flags come from analog comparators outside the block: supply above the power-on-reset threshold, supply above the write-inhibit threshold, and supply above the minimum operating level. While the first flag is low, everything is held in reset and the core reset output stays asserted. Two independent saturating timers, clocked by a free-running clock, measure how long each of the other two flags has been high.

Reads become legal once the select timer (minimum operating level) has expired. Write-class commands need both the select timer and the write timer (write-inhibit threshold) to have expired. A decoded command arrives as a one-cycle valid pulse with a 3-bit kind. The stream has no back-pressure: there is no ready signal, and every valid cycle is judged at once. A permitted command produces a one-cycle accept strobe with its kind echoed on the next cycle. A refused command is dropped and leaves no trace.

Top module: `pwrup_gate`

## Requirements
- R1: While `above_por_i` is low, `core_rst_o` is 1 and `rd_permit_o`, `wr_permit_o` and `acc_o` are 0. `core_rst_o` falls after `SYNC_STAGES` rising clock edges with `above_por_i` high.
- R2: `rd_permit_o` is 1 exactly when `min_ok_i` has been sampled high on at least `SEL_DLY` consecutive rising edges and `core_rst_o` is 0.
- R3: `wr_permit_o` is 1 exactly when `rd_permit_o` is 1 and `wi_ok_i` has been sampled high on at least `WR_DLY` consecutive rising edges.
- R4: A rising edge that samples `min_ok_i` (or `wi_ok_i`) low clears that timer, so the matching permit is 0 after that edge. The count restarts from zero when the flag is next high.
- R5: Kind 0 (read-class) with `cmd_valid_i` high is accepted when `rd_permit_o` is 1 at that edge, even while the write timer is still counting.
- R6: Kinds 1 to 5 (write enable, page program, block erase, chip erase, status write) are accepted only when `wr_permit_o` is 1 at that edge.
- R7: Kinds 6 and 7 are reserved and are never accepted.
- R8: An accepted command gives `acc_o` = 1 for exactly the cycle after its valid edge, with `acc_kind_o` equal to its kind. A refused command gives `acc_o` = 0 in that cycle and is not retried.
- R9: The timers saturate. Once expired, a permit stays at 1 for as long as its flags stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| above_por_i | input | 1 | Supply above power-on-reset threshold; low resets the block asynchronously |
| wi_ok_i | input | 1 | Supply above write-inhibit threshold |
| min_ok_i | input | 1 | Supply above minimum operating level |
| cmd_valid_i | input | 1 | Decoded command present this cycle |
| cmd_kind_i | input | 3 | Command kind: 0 read, 1-5 write-class, 6-7 reserved |
| core_rst_o | output | 1 | Reset to the memory core |
| rd_permit_o | output | 1 | Read-class commands allowed |
| wr_permit_o | output | 1 | Write-class commands allowed |
| acc_o | output | 1 | One-cycle accept strobe |
| acc_kind_o | output | 3 | Kind of the accepted command |

## Verification
Timer counts and reset release change on a rising edge and are visible at once, so the permits are compared at the falling edge that follows the edge on which the bench model advances. A command driven before edge n is judged against the permits in force at edge n. Its strobe is due one cycle later, at the falling edge after edge n. The bench keeps a per-edge arithmetic model of both timer counts and the reset release count, and compares every output at every falling edge. It sweeps the gap between the two flag rises and then drops each flag mid-run.

// File: rtl/pug_pkg.sv
package pug_pkg;
  typedef enum logic [2:0] {
    K_READ   = 3'd0,
    K_WREN   = 3'd1,
    K_PROG   = 3'd2,
    K_BERASE = 3'd3,
    K_CERASE = 3'd4,
    K_WRSTAT = 3'd5,
    K_RSV6   = 3'd6,
    K_RSV7   = 3'd7
  } cmd_kind_e;

  function automatic logic is_wr_class(input logic [2:0] k);
    return (k >= 3'd1) && (k <= 3'd5);
  endfunction

  function automatic logic is_rd_class(input logic [2:0] k);
    return k == 3'd0;
  endfunction
endpackage

// File: rtl/pug_timer.sv
module pug_timer #(
  parameter int unsigned DLY = 16
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (DLY < 2) ? 1 : $clog2(DLY + 1);
  localparam logic [CW-1:0] LIM = CW'(DLY);

  logic [CW-1:0] cnt_q;

  // Saturating count of consecutive edges with run_i high.
  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i)          cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/pug_rst_sync.sv
module pug_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) q <= 1'b0;
        else           q <= 1'b1;
      end
      assign rst_o = ~q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) q <= '0;
        else           q <= {q[STAGES-2:0], 1'b1};
      end
      assign rst_o = ~q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pug_cmd_gate.sv
module pug_cmd_gate
  import pug_pkg::*;
(
  input  logic       clk_i,
  input  logic       arst_n_i,
  input  logic       rd_ok_i,
  input  logic       wr_ok_i,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_kind_i,
  output logic       acc_o,
  output logic [2:0] acc_kind_o
);
  logic take;

  always_comb begin
    take = 1'b0;
    if (cmd_valid_i) begin
      if (is_rd_class(cmd_kind_i))      take = rd_ok_i;
      else if (is_wr_class(cmd_kind_i)) take = wr_ok_i;
    end
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      acc_o      <= 1'b0;
      acc_kind_o <= 3'd0;
    end else begin
      acc_o <= take;
      if (take) acc_kind_o <= cmd_kind_i;
    end
  end
endmodule

// File: rtl/pwrup_gate.sv
module pwrup_gate #(
  parameter int unsigned SEL_DLY     = 300,
  parameter int unsigned WR_DLY      = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       above_por_i,
  input  logic       wi_ok_i,
  input  logic       min_ok_i,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_kind_i,
  output logic       core_rst_o,
  output logic       rd_permit_o,
  output logic       wr_permit_o,
  output logic       acc_o,
  output logic [2:0] acc_kind_o
);
  logic sel_done, wi_done;

  pug_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .arst_n_i(above_por_i), .rst_o(core_rst_o)
  );

  pug_timer #(.DLY(SEL_DLY)) u_sel_tmr (
    .clk_i(clk_i), .arst_n_i(above_por_i), .run_i(min_ok_i), .done_o(sel_done)
  );

  pug_timer #(.DLY(WR_DLY)) u_wr_tmr (
    .clk_i(clk_i), .arst_n_i(above_por_i), .run_i(wi_ok_i), .done_o(wi_done)
  );

  assign rd_permit_o = sel_done & ~core_rst_o;
  assign wr_permit_o = rd_permit_o & wi_done;

  pug_cmd_gate u_gate (
    .clk_i(clk_i), .arst_n_i(above_por_i),
    .rd_ok_i(rd_permit_o), .wr_ok_i(wr_permit_o),
    .cmd_valid_i(cmd_valid_i), .cmd_kind_i(cmd_kind_i),
    .acc_o(acc_o), .acc_kind_o(acc_kind_o)
  );
endmodule

// File: rtl/pwrup_gate_chk.sv
module pwrup_gate_chk (
  input logic       clk_i,
  input logic       above_por_i,
  input logic       wi_ok_i,
  input logic       min_ok_i,
  input logic       cmd_valid_i,
  input logic       core_rst_o,
  input logic       rd_permit_o,
  input logic       wr_permit_o,
  input logic       acc_o,
  input logic [2:0] acc_kind_o
);
  a_r1_reset_holds: assert property (@(posedge clk_i)
    !above_por_i |-> (core_rst_o && !acc_o && !rd_permit_o));

  a_r1_no_permit_in_reset: assert property (@(posedge clk_i) disable iff (!above_por_i)
    core_rst_o |-> (!rd_permit_o && !wr_permit_o));

  a_r4_wi_drop_clears: assert property (@(posedge clk_i) disable iff (!above_por_i)
    !wi_ok_i |=> !wr_permit_o);

  a_r4_min_drop_clears: assert property (@(posedge clk_i) disable iff (!above_por_i)
    !min_ok_i |=> !rd_permit_o);

  a_r5_read_needs_permit: assert property (@(posedge clk_i) disable iff (!above_por_i)
    (acc_o && acc_kind_o == 3'd0) |-> $past(rd_permit_o));

  a_r6_write_needs_permit: assert property (@(posedge clk_i) disable iff (!above_por_i)
    (acc_o && acc_kind_o != 3'd0) |-> $past(wr_permit_o));

  a_r7_no_reserved: assert property (@(posedge clk_i) disable iff (!above_por_i)
    acc_o |-> (acc_kind_o <= 3'd5));

  a_r8_strobe_follows_valid: assert property (@(posedge clk_i) disable iff (!above_por_i)
    acc_o |-> $past(cmd_valid_i));

  a_r9_permit_sticks: assert property (@(posedge clk_i) disable iff (!above_por_i)
    (wr_permit_o && wi_ok_i && min_ok_i) |=> wr_permit_o);
endmodule

bind pwrup_gate pwrup_gate_chk u_chk (
  .clk_i(clk_i), .above_por_i(above_por_i), .wi_ok_i(wi_ok_i),
  .min_ok_i(min_ok_i), .cmd_valid_i(cmd_valid_i),
  .core_rst_o(core_rst_o), .rd_permit_o(rd_permit_o),
  .wr_permit_o(wr_permit_o), .acc_o(acc_o), .acc_kind_o(acc_kind_o)
);

// File: tb/test_pwrup_gate.sv
module test_pwrup_gate;
  localparam int CLK_PERIOD = 10;
  localparam int SEL = 3;
  localparam int WR  = 6;
  localparam int SS  = 2;

  logic clk = 1'b0;
  logic above_por, wi_ok, min_ok, cmd_valid;
  logic [2:0] cmd_kind;
  logic core_rst, rd_permit, wr_permit, acc;
  logic [2:0] acc_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrup_gate #(.SEL_DLY(SEL), .WR_DLY(WR), .SYNC_STAGES(SS)) i_pwrup_gate (
    .clk_i(clk), .above_por_i(above_por), .wi_ok_i(wi_ok), .min_ok_i(min_ok),
    .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind),
    .core_rst_o(core_rst), .rd_permit_o(rd_permit), .wr_permit_o(wr_permit),
    .acc_o(acc), .acc_kind_o(acc_kind)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_por = 0, m_sel = 0, m_wi = 0;
  logic e_acc = 1'b0;
  logic [2:0] e_kind = 3'd0;
  string wtag = "R3";

  function automatic logic e_rd();
    return (m_sel == SEL) && (m_por >= SS);
  endfunction
  function automatic logic e_wr();
    return e_rd() && (m_wi == WR);
  endfunction
  function automatic string kind_tag(input logic [2:0] k);
    if (k == 3'd0) return "R5";
    if (k <= 3'd5) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1", core_rst, (m_por >= SS) ? 0 : 1);
    chk("R2", rd_permit, e_rd());
    chk(wtag, wr_permit, e_wr());
    chk({kind_tag(e_kind), "/R8"}, acc, e_acc);
    if (e_acc) chk("R8", acc_kind, e_kind);
  endtask

  // One clock: commit a command (if any), advance the model, compare at negedge.
  task automatic step(input logic v);
    logic [2:0] k;
    k = 3'(cyc % 8);
    cmd_valid = v;
    cmd_kind  = k;
    @(posedge clk);
    if (above_por) begin
      e_acc  = v && ((k == 3'd0 && e_rd()) || (k >= 3'd1 && k <= 3'd5 && e_wr()));
      if (e_acc) e_kind = k;
      m_por = (m_por < SS) ? m_por + 1 : m_por;
      m_sel = !min_ok ? 0 : ((m_sel < SEL) ? m_sel + 1 : m_sel);
      m_wi  = !wi_ok  ? 0 : ((m_wi  < WR)  ? m_wi  + 1 : m_wi);
    end
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step((cyc % 3) != 2);
  endtask

  task automatic por_off();
    above_por = 1'b0;
    m_por = 0; m_sel = 0; m_wi = 0; e_acc = 1'b0; e_kind = 3'd0;
    #1;
    wtag = "R3";
    compare(); // R1: asynchronous reset state
  endtask

  initial begin
    above_por = 1'b0; wi_ok = 1'b0; min_ok = 1'b0;
    cmd_valid = 1'b0; cmd_kind = 3'd0;
    @(negedge clk);
    compare(); // R1 reset state
    for (int d = 0; d <= 9; d++) begin
      por_off();
      min_ok = 1'b0; wi_ok = 1'b0;
      run(3);                       // R1: commands dropped in reset
      above_por = 1'b1;
      run(1);
      min_ok = 1'b1;
      run(d);                       // R5: reads while write timer idle
      wi_ok = 1'b1;
      run(WR + 3);
      wtag = "R9";
      run(20);                      // R9: saturation holds
      wtag = "R4";
      wi_ok = 1'b0;
      run(2);
      wi_ok = 1'b1;
      run(WR + 2);                  // R4: restart from zero
      min_ok = 1'b0;
      run(2);
      min_ok = 1'b1;
      run(SEL + 3);
      wtag = "R3";
    end
    por_off();
    run(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule